// File: doc/BRIEF.md
# Serial ADC Readout Port

This block is the peripheral side of a serial analog-to-digital converter's data output. An abstract conversion engine sits beside it. The engine reports the end of each conversion with a one-cycle `conv_done` pulse and presents the sign, out-of-range flag, result bits and sub-LSB bits at the same time. The block keeps those values and serves them to an external readout master as a 32-bit frame. The frame is shifted out on the falling edges of the master's serial clock while chip select is low.

Before the first shift, the data line shows the live end-of-conversion level. This level is high while a conversion runs and drops as soon as a result is ready, so the master can poll it or use it as an interrupt. Completing a full frame starts the next conversion. The block pulses `conv_start` and reports busy until the engine answers. The block is a synthesizable stand-in that lets a readout master be verified against realistic framing.

The serial clock and chip select are sampled in the `clk` domain. A falling serial-clock edge is seen as `sck` high in one cycle and low in the next.

Top module: `adc_serial_port`

## Requirements
- R1: While `cs_n` is high, `sdo_oe` is 0 and `sdo` reads 0, and serial-clock edges neither shift data nor advance the frame: the next read still starts with the end-of-conversion bit followed by bit 30.
- R2: With `cs_n` low and no bit shifted yet, `sdo` shows the end-of-conversion level. It is 1 while converting and 0 from the first clock edge after a `conv_done` pulse. A master sampling it before the first falling edge reads bit 31 = 0 on a ready result.
- R3: While a conversion is running and no bit has been shifted, falling serial-clock edges are ignored and `sdo` stays 1.
- R4: The first falling edge after the result is ready loads the frame and shows bit 30, which is always 0.
- R5: The frame is sent MSB first. Bit 29 is the sign (1 = positive input, 0 = negative). Bit 28 is the out-of-range flag (1 = above the reference or below zero). Bits 27 down to 4 are the 24 result bits, MSB first. Bits 3 down to 0 are the sub-LSB bits, MSB first. Bit 0 appears after the 31st falling edge.
- R6: The 32nd falling edge drives `sdo` to 1 and raises `conv_start` for exactly one cycle.
- R7: After `conv_start`, the block reports busy until a `conv_done` pulse arrives. A `conv_done` pulse while not busy is ignored.
- R8: A rise of `cs_n` in mid-frame clears the bit position. The next read starts again from the end-of-conversion bit and returns the same frame.
- R9: The result inputs are captured on the accepted `conv_done` pulse. Later changes on them do not alter the frame served.
- R10: After reset the block is busy (end-of-conversion level 1), `conv_start` is 0 and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select from the master |
| sck | input | 1 | Serial clock from the master, sampled on `clk` |
| conv_done | input | 1 | One-cycle pulse: conversion finished |
| res_sign | input | 1 | Sign of the result, 1 = positive |
| res_over | input | 1 | Out-of-range flag |
| res_data | input | DW (24) | Conversion result |
| res_sub | input | SW (4) | Sub-LSB bits |
| sdo | output | 1 | Serial data, 0 when not enabled |
| sdo_oe | output | 1 | Output enable of the data line (0 = high impedance) |
| conv_start | output | 1 | One-cycle pulse: a new conversion begins |

## Verification
The assertions assume that `sck` holds each level for at least one `clk` cycle and changes only between rising `clk` edges. They also assume that `conv_done` is a single-cycle pulse that never coincides with `conv_start`. The bench drives every input on the falling edge of `clk`, with one clock per serial half-period. It lets the conversion engine answer only some cycles after a frame completes. It also raises `conv_done` once while the block is idle, to check that the pulse is ignored there.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int DW = 24,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          conv_done,
  input  logic          res_sign,
  input  logic          res_over,
  input  logic [DW-1:0] res_data,
  input  logic [SW-1:0] res_sub,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          conv_start
);
  localparam int FW = 4 + DW + SW;
  localparam int HW = FW - 2;
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);

  logic          sck_q;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [FW-1:0] sh;
  logic [HW-1:0] hold;

  wire fall  = !cs_n && sck_q && !sck;
  wire first = fall && (cnt == '0) && !busy;
  wire mid   = fall && (cnt != '0);
  wire last  = mid && (cnt == LAST);

  assign sdo_oe = !cs_n;
  assign sdo    = sdo_oe && ((cnt == '0) ? busy : sh[FW-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q      <= 1'b0;
      busy       <= 1'b1;
      cnt        <= '0;
      sh         <= '0;
      hold       <= '0;
      conv_start <= 1'b0;
    end else begin
      sck_q      <= sck;
      conv_start <= last;
      if (busy && conv_done) begin
        busy <= 1'b0;
        hold <= {res_sign, res_over, res_data, res_sub};
      end else if (last) begin
        busy <= 1'b1;
      end
      if (cs_n) begin
        cnt <= '0;
      end else if (first) begin
        cnt <= CW'(1);
        sh  <= {1'b0, hold, 1'b0};
      end else if (last) begin
        cnt <= '0;
      end else if (mid) begin
        cnt <= cnt + CW'(1);
        sh  <= {sh[FW-2:0], 1'b0};
      end
    end
  end

  AST_IDLE_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt == '0)); // R8
  AST_BUSY_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == '0) |=> (cnt == '0)); // R3
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R6
  AST_START_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start) |-> ($past(cnt) == LAST)); // R6
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R7
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> busy); // R7
  AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> $stable(hold)); // R9
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
  localparam int DW = 24;
  localparam int SW = 4;
  localparam int FW = 4 + DW + SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic conv_done = 1'b0;
  logic res_sign = 1'b0;
  logic res_over = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic [SW-1:0] res_sub = '0;
  logic sdo, sdo_oe, conv_start;

  int errors = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  adc_serial_port #(.DW(DW), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .conv_done(conv_done),
    .res_sign(res_sign), .res_over(res_over), .res_data(res_data), .res_sub(res_sub),
    .sdo(sdo), .sdo_oe(sdo_oe), .conv_start(conv_start));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic push_frame(input logic s, input logic o, input logic [DW-1:0] d,
                            input logic [SW-1:0] u, input int n);
    logic [FW-1:0] w;
    w = {2'b00, s, o, d, u};
    for (int i = FW - 1; i >= FW - n; i--) begin
      exp_q.push_back(w[i]);
      if (i == FW - 1) tag_q.push_back("R2");
      else if (i == FW - 2) tag_q.push_back("R4");
      else tag_q.push_back("R5");
    end
  endtask

  always @(posedge sck) begin
    if (mon_en && !cs_n) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R5: got %b expected no bit", sdo);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, sdo, e);
      end
    end
  end

  task automatic sck_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1;
      @(negedge clk);
      sck = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic engine_done(input logic s, input logic o, input logic [DW-1:0] d,
                             input logic [SW-1:0] u);
    res_sign = s; res_over = o; res_data = d; res_sub = u;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic read(input logic s, input logic o, input logic [DW-1:0] d,
                      input logic [SW-1:0] u, input int n);
    push_frame(s, o, d, u, n);
    mon_en = 1'b1;
    cs_n = 1'b0;
    @(negedge clk);
    sck_cycles(n);
    mon_en = 1'b0;
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5: got %0d bits left expected 0", exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", sdo_oe, 1'b0);
    check("R10", conv_start, 1'b0);
    check("R1", sdo, 1'b0);
    // R1: edges with chip select high are ignored
    sck_cycles(5);
    check("R1", sdo_oe, 1'b0);
    cs_n = 1'b0;
    @(negedge clk);
    check("R10", sdo, 1'b1);
    check("R10", sdo_oe, 1'b1);
    // R3: falling edges while converting
    sck_cycles(3);
    check("R3", sdo, 1'b1);
    conv_done = 1'b1;
    res_sign = 1'b1; res_over = 1'b0; res_data = 24'hA5C3_1E; res_sub = 4'h9;
    @(negedge clk);
    conv_done = 1'b0;
    check("R2", sdo, 1'b0);
    cs_n = 1'b1;
    @(negedge clk);
    // R9: input changes after capture are not served
    res_data = 24'h000000; res_sign = 1'b0; res_sub = 4'h0;
    read(1'b1, 1'b0, 24'hA5C3_1E, 4'h9, FW);
    check("R6", sdo, 1'b1);
    check("R6", conv_start, 1'b1);
    @(negedge clk);
    check("R6", conv_start, 1'b0);
    sck_cycles(2);
    check("R7", sdo, 1'b1);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    engine_done(1'b0, 1'b1, 24'hFFFFFF, 4'h3);
    // R7: a done pulse while idle is ignored
    engine_done(1'b1, 1'b1, 24'h123456, 4'hC);
    cs_n = 1'b0;
    @(negedge clk);
    check("R2", sdo, 1'b0);
    cs_n = 1'b1;
    @(negedge clk);
    // R8: abort after ten bits
    read(1'b0, 1'b1, 24'hFFFFFF, 4'h3, 10);
    cs_n = 1'b1;
    @(negedge clk);
    check("R8", sdo_oe, 1'b0);
    sck_cycles(3);
    read(1'b0, 1'b1, 24'hFFFFFF, 4'h3, FW);
    check("R6", conv_start, 1'b1);
    cs_n = 1'b1;
    @(negedge clk);
    engine_done(1'b1, 1'b1, 24'h000001, 4'hF);
    read(1'b1, 1'b1, 24'h000001, 4'hF, FW);
    check("R6", sdo, 1'b1);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule